// File: doc/BRIEF.md
# Serial EEPROM Controller with Station Address Autoload

This block drives a three-wire serial EEPROM organised as 128 bytes of 8 bits. After a hard or soft reset it runs an autoload sequence. The sequence reads a signature byte from location 0x00. When that byte is 0xA5, the sequence copies the six bytes at locations 0x01 to 0x06 into a 48-bit station address register and raises a loaded flag. For any other value, the sequence stops with the flag low.

Once autoload has finished, a host issues one-shot commands through a command port and an 8-bit data register. Each command carries a 3-bit opcode and a 7-bit address. The host starts a command by pulsing `cmd_wr`, which sets the busy flag, and then waits for busy to fall. The same serial bit engine serves both autoload and host commands. After a program or erase frame, the engine polls the memory for ready, and a cycle limit guards that poll. A divider input sets the serial clock rate.

Top module: `eeprom_ctl`

## Requirements
- R1: While reset is active, `ee_cs`, `ee_sk`, `busy`, `mac_loaded` and `timeout` are low and `mac` is zero. `init_busy` is high.
- R2: Autoload starts after a hard reset and after `soft_rst`, and `init_busy` stays high until it ends. A `cmd_wr` given while `init_busy` is high is refused, and `busy` stays low.
- R3: If location 0x00 holds 0xA5, locations 0x01..0x06 land in `mac[7:0]` through `mac[47:40]` in that order. `mac_loaded` rises once all six bytes are stored, and busy and `init_busy` are low at that point.
- R4: If the signature differs from 0xA5, the sequence ends with `mac_loaded` low and `mac` unchanged. A hard reset clears `mac`, while a soft reset keeps it.
- R5: Host opcode 7 (reload) clears `mac_loaded`, sets busy and repeats the R3/R4 sequence. `mac_loaded` then reports whether the reload succeeded.
- R6: Host opcodes are 0 read, 1 write, 2 erase, 3 program-enable, 4 program-disable, 5 write-all, 6 erase-all. A `cmd_wr` accepted with busy low sets busy on the next cycle. Busy falls when the operation ends, and after a read `rdata` then holds the fetched byte.
- R7: Every frame starts with a 1 and is sent MSB first. Read sends opcode 10 plus the address, write sends 01 plus the address, and erase sends 11 plus the address. Opcode 00 is sent with an address prefix of 11 for program-enable, 00 for program-disable, 01 for write-all and 10 for erase-all. A read adds one dummy clock and then samples 8 data bits on rising `ee_sk`.
- R8: Write and write-all send the byte last loaded through `data_wr`. Write and erase use `cmd_addr`.
- R9: After a write, erase, write-all or erase-all frame, `ee_cs` falls for at least one `ee_sk` period and then rises again. Busy does not fall until `ee_di` reads high.
- R10: If `ee_di` stays low for `TMO_CYC` cycles of the poll, `timeout` is set on the cycle before busy falls. The next accepted command clears `timeout`.
- R11: Each `ee_sk` half period lasts `clk_div`+1 system clock cycles.
- R12: `ee_sk` is low whenever `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset; restarts autoload |
| clk_div | input | DIV_W | Serial clock half period minus one, in clk cycles |
| cmd_wr | input | 1 | Command strobe; sets busy |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | 7 | Memory location for read, write, erase |
| data_wr | input | 1 | Loads the data register while not busy |
| data_in | input | 8 | Byte for write and write-all |
| busy | output | 1 | Host command in progress |
| init_busy | output | 1 | Reset-time autoload in progress |
| rdata | output | 8 | Data register |
| mac | output | 48 | Station address |
| mac_loaded | output | 1 | Last autoload or reload succeeded |
| timeout | output | 1 | Last ready poll expired |
| ee_cs | output | 1 | Serial chip select |
| ee_sk | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to memory |
| ee_di | input | 1 | Serial data from memory |

## Verification
A wrong bit count or phase in the serial engine shows up as a corrupted `rdata` at the next busy fall. A frame that is one clock long or short desynchronises the memory, so every later read fails. A broken autoload index shows in `mac` within seven frames of reset, either as swapped bytes or as `mac_loaded` raised on a bad signature. A stuck poll state holds busy high until the timeout limit passes and shows up as `timeout` set where the memory was ready.

// File: rtl/eeprom_ctl.sv
module eeprom_ctl #(
  parameter int DIV_W   = 8,
  parameter int TMO_CYC = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             cmd_wr,
  input  logic [2:0]       cmd_op,
  input  logic [6:0]       cmd_addr,
  input  logic             data_wr,
  input  logic [7:0]       data_in,
  output logic             busy,
  output logic             init_busy,
  output logic [7:0]       rdata,
  output logic [47:0]      mac,
  output logic             mac_loaded,
  output logic             timeout,
  output logic             ee_cs,
  output logic             ee_sk,
  output logic             ee_do,
  input  logic             ee_di
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [7:0] SIG = 8'hA5;
  localparam logic [2:0] OP_READ = 3'd0, OP_WRITE = 3'd1, OP_ERASE = 3'd2, OP_WEN = 3'd3,
                         OP_WDIS = 3'd4, OP_WRALL = 3'd5, OP_ERALL = 3'd6, OP_RELOAD = 3'd7;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_DONE} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_cnt;
  logic [17:0]      tx;
  logic [4:0]       bit_cnt, nbits;
  logic [7:0]       rx, data_q;
  logic             is_rd, need_poll, gap_cnt, auto_run;
  logic [TW-1:0]    tmo_cnt;
  logic [2:0]       idx;

  logic       tick, accept, launch, l_rd, l_poll;
  logic [2:0] l_op;
  logic [6:0] l_addr;
  logic [9:0] l_hdr;
  logic [4:0] l_nb;
  logic [2:0] bidx;

  assign tick   = (div_cnt == clk_div);
  assign accept = cmd_wr && !busy && !init_busy && !auto_run;
  assign launch = (st == S_IDLE && auto_run) || (accept && cmd_op != OP_RELOAD);
  assign l_op   = auto_run ? OP_READ : cmd_op;
  assign l_addr = auto_run ? {4'd0, idx} : cmd_addr;
  assign l_rd   = (l_op == OP_READ);
  assign l_poll = (l_op == OP_WRITE) || (l_op == OP_ERASE) || (l_op == OP_WRALL) || (l_op == OP_ERALL);
  assign l_nb   = l_rd ? 5'd19 : ((l_op == OP_WRITE || l_op == OP_WRALL) ? 5'd18 : 5'd10);
  assign bidx   = idx - 3'd1;
  assign ee_do  = (st == S_SHIFT) && tx[17];
  assign rdata  = data_q;

  always_comb begin
    case (l_op)
      OP_WRITE: l_hdr = {3'b101, l_addr};
      OP_ERASE: l_hdr = {3'b111, l_addr};
      OP_WEN:   l_hdr = {3'b100, 2'b11, 5'd0};
      OP_WDIS:  l_hdr = {3'b100, 2'b00, 5'd0};
      OP_WRALL: l_hdr = {3'b100, 2'b01, 5'd0};
      OP_ERALL: l_hdr = {3'b100, 2'b10, 5'd0};
      default:  l_hdr = {3'b110, l_addr};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; div_cnt <= '0; tx <= '0; bit_cnt <= '0; nbits <= '0;
      rx <= '0; data_q <= '0; is_rd <= 1'b0; need_poll <= 1'b0; gap_cnt <= 1'b0;
      tmo_cnt <= '0; idx <= '0; auto_run <= 1'b1; init_busy <= 1'b1;
      busy <= 1'b0; mac_loaded <= 1'b0; timeout <= 1'b0; ee_cs <= 1'b0; ee_sk <= 1'b0;
      mac <= '0;
    end else if (soft_rst) begin
      st <= S_IDLE; div_cnt <= '0; tx <= '0; bit_cnt <= '0; nbits <= '0;
      rx <= '0; data_q <= '0; is_rd <= 1'b0; need_poll <= 1'b0; gap_cnt <= 1'b0;
      tmo_cnt <= '0; idx <= '0; auto_run <= 1'b1; init_busy <= 1'b1;
      busy <= 1'b0; mac_loaded <= 1'b0; timeout <= 1'b0; ee_cs <= 1'b0; ee_sk <= 1'b0;
    end else begin
      div_cnt <= (tick || !(st == S_SHIFT || st == S_GAP)) ? '0 : div_cnt + 1'b1;
      if (data_wr && !busy) data_q <= data_in;
      if (accept) begin
        busy    <= 1'b1;
        timeout <= 1'b0;
        if (cmd_op == OP_RELOAD) begin
          auto_run   <= 1'b1;
          idx        <= '0;
          mac_loaded <= 1'b0;
        end
      end
      case (st)
        S_IDLE: if (launch) begin
          st        <= S_SHIFT;
          ee_cs     <= 1'b1;
          tx        <= {l_hdr, data_q};
          bit_cnt   <= '0;
          nbits     <= l_nb;
          is_rd     <= l_rd;
          need_poll <= l_poll;
        end
        S_SHIFT: if (tick) begin
          if (!ee_sk) begin
            ee_sk <= 1'b1;
            if (is_rd && bit_cnt >= 5'd11) rx <= {rx[6:0], ee_di};
          end else begin
            ee_sk <= 1'b0;
            if (bit_cnt == nbits - 5'd1) begin
              ee_cs   <= 1'b0;
              gap_cnt <= 1'b0;
              st      <= need_poll ? S_GAP : S_DONE;
            end else begin
              bit_cnt <= bit_cnt + 5'd1;
              tx      <= {tx[16:0], 1'b0};
            end
          end
        end
        S_GAP: if (tick) begin
          gap_cnt <= 1'b1;
          if (gap_cnt) begin
            ee_cs   <= 1'b1;
            tmo_cnt <= '0;
            st      <= S_POLL;
          end
        end
        S_POLL: begin
          if (ee_di) begin
            ee_cs <= 1'b0;
            st    <= S_DONE;
          end else if (tmo_cnt == TW'(TMO_CYC - 1)) begin
            ee_cs   <= 1'b0;
            timeout <= 1'b1;
            st      <= S_DONE;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        default: begin
          st <= S_IDLE;
          if (auto_run) begin
            if (idx == 3'd0 && rx != SIG) begin
              auto_run  <= 1'b0;
              init_busy <= 1'b0;
              busy      <= 1'b0;
            end else begin
              if (idx != 3'd0) mac[{bidx, 3'b000} +: 8] <= rx;
              if (idx == 3'd6) begin
                mac_loaded <= 1'b1;
                auto_run   <= 1'b0;
                init_busy  <= 1'b0;
                busy       <= 1'b0;
              end else begin
                idx <= idx + 3'd1;
              end
            end
          end else begin
            busy <= 1'b0;
            if (is_rd) data_q <= rx;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/eeprom_ctl_chk.sv
module eeprom_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        busy,
  input logic        init_busy,
  input logic        mac_loaded,
  input logic        timeout,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic [47:0] mac
);
  // R6
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_wr));
  // R2
  init_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && init_busy) |=> !busy);
  // R3
  loaded_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_loaded) |-> (!busy && !init_busy));
  // R4
  bad_sig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(init_busy) && !mac_loaded) |-> $stable(mac));
  // R10
  timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |=> $fell(busy));
  // R12
  sk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs |-> !ee_sk);
endmodule

bind eeprom_ctl eeprom_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .busy(busy), .init_busy(init_busy),
  .mac_loaded(mac_loaded), .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .mac(mac)
);

// File: tb/eeprom_ctl_test.sv
module eeprom_ctl_test;
  logic clk = 0, rst_n = 0, soft_rst = 0;
  logic [7:0] clk_div = 8'd1;
  logic cmd_wr = 0, data_wr = 0;
  logic [2:0] cmd_op = 0;
  logic [6:0] cmd_addr = 0;
  logic [7:0] data_in = 0;
  logic busy, init_busy, mac_loaded, timeout, ee_cs, ee_sk, ee_do, ee_di;
  logic [7:0] rdata;
  logic [47:0] mac;
  int total = 0, fails = 0;
  longint cyc = 0, last_rise = 0, sk_period = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;
  always @(posedge ee_sk) begin sk_period = cyc - last_rise; last_rise = cyc; end

  eeprom_ctl #(.DIV_W(8), .TMO_CYC(600)) uut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .clk_div(clk_div), .cmd_wr(cmd_wr),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .data_wr(data_wr), .data_in(data_in),
    .busy(busy), .init_busy(init_busy), .rdata(rdata), .mac(mac), .mac_loaded(mac_loaded),
    .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di));

  // memory model
  logic [7:0] mem [128];
  logic we_en = 0, started = 0, after_prog = 0, prog_busy = 0, stuck = 0, rd_bit = 0, rd_phase = 0;
  int mcnt = 0;
  logic [1:0] m_op = 0;
  logic [6:0] m_a = 0;
  logic [7:0] m_d = 0;
  event prog_ev;
  assign ee_di = ee_cs & (rd_phase ? rd_bit : (after_prog & !prog_busy));

  always @(posedge ee_sk) if (ee_cs) begin
    if (!started) begin
      if (ee_do) begin started = 1; mcnt = 0; after_prog = 0; end
    end else begin
      if (mcnt < 2) m_op = {m_op[0], ee_do};
      else if (mcnt < 9) m_a = {m_a[5:0], ee_do};
      else if (mcnt < 17) m_d = {m_d[6:0], ee_do};
      mcnt++;
    end
  end
  always @(negedge ee_sk) if (ee_cs && started && m_op == 2'b10 && mcnt >= 9) begin
    rd_phase = 1;
    rd_bit = (mcnt == 9) ? 1'b0 : mem[m_a][17 - mcnt];
  end
  always @(negedge ee_cs) begin
    if (started) begin
      case (m_op)
        2'b01: begin after_prog = 1; if (we_en) begin mem[m_a] = m_d; -> prog_ev; end end
        2'b11: begin after_prog = 1; if (we_en) begin mem[m_a] = 8'hFF; -> prog_ev; end end
        2'b00: case (m_a[6:5])
          2'b11: we_en = 1;
          2'b00: we_en = 0;
          2'b01: begin after_prog = 1; if (we_en) begin for (int i = 0; i < 128; i++) mem[i] = m_d; -> prog_ev; end end
          default: begin after_prog = 1; if (we_en) begin for (int i = 0; i < 128; i++) mem[i] = 8'hFF; -> prog_ev; end end
        endcase
        default: ;
      endcase
    end
    started = 0; rd_phase = 0;
  end
  always @(prog_ev) begin prog_busy = 1; #2000; wait (!stuck); prog_busy = 0; end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [6:0] a);
    while (busy || init_busy) @(negedge clk);
    @(negedge clk); cmd_op = op; cmd_addr = a; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    while (busy) @(negedge clk);
  endtask

  task automatic setd(input logic [7:0] d);
    @(negedge clk); data_in = d; data_wr = 1;
    @(negedge clk); data_wr = 0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp, input string req);
    cmd(3'd0, a);
    chk(rdata == exp, req, {40'd0, rdata}, {40'd0, exp});
  endtask

  initial begin
    #(200000 * 8);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [47:0] exp_mac;
    longint t0;
    mem[0] = 8'hA5;
    for (int i = 1; i < 128; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!ee_cs && !ee_sk && !busy && !mac_loaded && !timeout && mac == 0 && init_busy,
        "R1", {ee_cs, ee_sk, busy, mac_loaded, timeout, init_busy}, 6'b000001);
    rst_n = 1;
    @(negedge clk); cmd_op = 3'd0; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    chk(!busy && init_busy, "R2 refused during autoload", {busy, init_busy}, 2'b01);
    while (init_busy) @(negedge clk);
    exp_mac = 0;
    for (int k = 0; k < 6; k++) exp_mac[k*8 +: 8] = pat(k + 1);
    chk(mac == exp_mac && mac_loaded, "R3 autoload", mac, exp_mac);
    chk(!ee_cs && !ee_sk, "R12 idle pins", {ee_cs, ee_sk}, 0);

    // R6 R7 R11 read sweep over all locations and four divider settings
    for (int d = 0; d < 4; d++) begin
      clk_div = 8'(d);
      for (int a = d; a < 128; a += 4) rd_chk(7'(a), a == 0 ? 8'hA5 : pat(a), "R6 R7 read");
      chk(sk_period == 2 * (d + 1), "R11 sk period", 48'(sk_period), 48'(2 * (d + 1)));
    end
    clk_div = 8'd1;

    // R8 R9 writes after enable
    cmd(3'd3, 0);
    for (int a = 8; a < 24; a++) begin
      setd(8'(a) ^ 8'h96);
      t0 = cyc;
      cmd(3'd1, 7'(a));
      if (a == 8) chk((cyc - t0) > 250, "R9 busy held until ready", 48'(cyc - t0), 48'd250);
    end
    for (int a = 8; a < 24; a++) rd_chk(7'(a), 8'(a) ^ 8'h96, "R8 write readback");
    rd_chk(7'd24, pat(24), "R8 neighbour untouched");
    cmd(3'd2, 7'd9);
    rd_chk(7'd9, 8'hFF, "R8 erase");
    rd_chk(7'd10, 8'd10 ^ 8'h96, "R8 erase only addressed");
    cmd(3'd4, 0);
    setd(8'h3C); cmd(3'd1, 7'd10);
    rd_chk(7'd10, 8'd10 ^ 8'h96, "R7 disable frame");
    cmd(3'd3, 0);
    setd(8'h5A); cmd(3'd5, 0);
    rd_chk(7'd0, 8'h5A, "R7 write-all"); rd_chk(7'd63, 8'h5A, "R7 write-all"); rd_chk(7'd127, 8'h5A, "R7 write-all");
    cmd(3'd6, 0);
    rd_chk(7'd0, 8'hFF, "R7 erase-all"); rd_chk(7'd100, 8'hFF, "R7 erase-all");

    // R4 R5 reload
    cmd(3'd7, 0);
    chk(!mac_loaded && mac == exp_mac, "R4 R5 failed reload", mac, exp_mac);
    setd(8'hA5); cmd(3'd1, 7'd0);
    for (int k = 1; k <= 6; k++) begin setd(8'(8'hC0 + k)); cmd(3'd1, 7'(k)); end
    cmd(3'd7, 0);
    for (int k = 0; k < 6; k++) exp_mac[k*8 +: 8] = 8'(8'hC1 + k);
    chk(mac_loaded && mac == exp_mac, "R5 reload", mac, exp_mac);

    // R10 timeout
    stuck = 1;
    setd(8'h11); cmd(3'd1, 7'd30);
    chk(timeout, "R10 timeout set", {47'd0, timeout}, 1);
    stuck = 0;
    repeat (300) @(negedge clk);
    rd_chk(7'd30, 8'h11, "R10 data after timeout");
    chk(!timeout, "R10 cleared", {47'd0, timeout}, 0);

    // R2 soft reset restarts autoload
    mem[1] = 8'h77;
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0; cmd_op = 3'd0; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    chk(init_busy && !busy, "R2 soft reset", {busy, init_busy}, 2'b01);
    while (init_busy) @(negedge clk);
    exp_mac[7:0] = 8'h77;
    chk(mac_loaded && mac == exp_mac, "R2 soft reload", mac, exp_mac);

    // R4 hard reset with bad signature
    mem[0] = 8'h00;
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    while (init_busy) @(negedge clk);
    chk(!mac_loaded && mac == 0, "R4 bad signature", mac, 0);
    chk(!ee_cs && !ee_sk, "R12 idle after", {ee_cs, ee_sk}, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule